// File: doc/BRIEF.md
# Programmable Modulo-N Frame Position Counter

This block tracks a position inside a repeating frame. Its count walks through the values 0 to N-1 and then starts over. N is taken from a runtime limit input and may be any value, including values that are not a power of two, such as 20 or 123. The block needs no divide or modulo unit. A wrap is found either by a magnitude compare or by the borrow out of a decrement.

A direction input picks one of two forms. In the ascending form the count rises, and it is checked against the live limit on every cycle. A new limit therefore takes effect at once. A count left above a newly lowered limit wraps on the next enabled clock. In the descending form the count falls toward zero. The borrow of count minus one serves both as the terminal test and as the source of the next value. A new limit is picked up only when the count reloads. A registered one-cycle pulse marks every wrap or reload.

Top module: `modn_frame_counter`

## Requirements
- R1: While `rst` is high at a clock edge, the count is set to 0 in the ascending form (`dir_down`=0). In the descending form (`dir_down`=1) it is set to the normalised limit minus one. `tc` is driven low.
- R2: In the ascending form, an enabled clock where the count is below limit-1 raises the count by one.
- R3: In the ascending form, an enabled clock where the count is at limit-1 returns it to 0. This holds for any limit, for example 20.
- R4: In the ascending form, the wrap test is a magnitude compare. A count at or above limit-1 goes to 0 on the next enabled clock, even after the limit has been lowered beneath it.
- R5: In the ascending form, a change to `limit` is used on the very next enabled clock.
- R6: In the descending form, an enabled clock with a nonzero count lowers the count by one.
- R7: In the descending form, an enabled clock with the count at 0 loads limit-1.
- R8: In the descending form, a change to `limit` has no effect until the next reload. The count keeps falling from its current value.
- R9: `tc` is high for exactly the one cycle that follows each enabled clock edge where a wrap or reload happened. It is low at all other times.
- R10: With `en` low, the count holds its value and `tc` stays low.
- R11: A `limit` of 0 or 1 acts as modulus 1. A count at 0 stays at 0, and `tc` is high after every enabled clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Count enable |
| dir_down | input | 1 | 0 = ascending form, 1 = descending form |
| limit | input | CNT_W | Modulus N, unsigned binary |
| count | output | CNT_W | Current frame position |
| tc | output | 1 | One-cycle wrap/reload pulse |

## Verification
The assertions check on every cycle how each enabled step relates to the previous count: increment, decrement, wrap to zero, or reload to limit-1. They also check the hold when `en` is low, the reset values, and that `tc` only follows an enabled edge. Only the bench scenarios can show the effects that span many cycles. These are a lowered limit catching a count that lies above it in the ascending form, and a new limit waiting out the descent in the descending form. The scenarios also cover full-length wraps at non-power-of-two limits and the modulus-1 corner.

// File: rtl/modn_pkg.sv
package modn_pkg;
  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } dir_t;
endpackage

// File: rtl/modn_limit_norm.sv
// Turns the raw modulus into the highest legal count value.
// Limits of 0 and 1 both give a top value of 0 (modulus 1).
module modn_limit_norm #(
  parameter int CNT_W = 8
) (
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] top
);
  always_comb begin
    if (limit <= CNT_W'(1)) top = '0;
    else                    top = limit - CNT_W'(1);
  end
endmodule

// File: rtl/modn_up_step.sv
// Ascending next value: a magnitude compare against the live top value.
module modn_up_step #(
  parameter int CNT_W = 8
) (
  input  logic [CNT_W-1:0] cur,
  input  logic [CNT_W-1:0] top,
  output logic [CNT_W-1:0] nxt,
  output logic             wrap
);
  always_comb begin
    wrap = (cur >= top);
    nxt  = wrap ? '0 : cur + CNT_W'(1);
  end
endmodule

// File: rtl/modn_down_step.sv
// Descending next value. One extra combinational bit carries the borrow
// of cur-1. That bit is the terminal test and is never stored.
module modn_down_step #(
  parameter int CNT_W = 8
) (
  input  logic [CNT_W-1:0] cur,
  input  logic [CNT_W-1:0] top,
  output logic [CNT_W-1:0] nxt,
  output logic             wrap
);
  localparam int EXT_W = CNT_W + 1;
  logic [EXT_W-1:0] diff;
  always_comb begin
    diff = {1'b0, cur} - EXT_W'(1);
    wrap = diff[CNT_W];
    nxt  = wrap ? top : diff[CNT_W-1:0];
  end
endmodule

// File: rtl/modn_frame_counter.sv
module modn_frame_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             dir_down,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] count,
  output logic             tc
);
  import modn_pkg::*;

  dir_t             dir;
  logic [CNT_W-1:0] top;
  logic [CNT_W-1:0] up_nxt, dn_nxt, sel_nxt;
  logic             up_wrap, dn_wrap, sel_wrap;
  logic [CNT_W-1:0] cnt_q;
  logic             tc_q;

  assign dir = dir_t'(dir_down);

  modn_limit_norm #(.CNT_W(CNT_W)) u_norm (.limit(limit), .top(top));
  modn_up_step    #(.CNT_W(CNT_W)) u_up   (.cur(cnt_q), .top(top), .nxt(up_nxt), .wrap(up_wrap));
  modn_down_step  #(.CNT_W(CNT_W)) u_dn   (.cur(cnt_q), .top(top), .nxt(dn_nxt), .wrap(dn_wrap));

  always_comb begin
    if (dir == DIR_DOWN) begin
      sel_nxt  = dn_nxt;
      sel_wrap = dn_wrap;
    end else begin
      sel_nxt  = up_nxt;
      sel_wrap = up_wrap;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= (dir == DIR_DOWN) ? top : '0;
      tc_q  <= 1'b0;
    end else begin
      tc_q <= en & sel_wrap;
      if (en) cnt_q <= sel_nxt;
    end
  end

  assign count = cnt_q;
  assign tc    = tc_q;
endmodule

// File: rtl/modn_frame_counter_chk.sv
module modn_frame_counter_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic             dir_down,
  input logic [CNT_W-1:0] limit,
  input logic [CNT_W-1:0] count,
  input logic             tc
);
  logic [CNT_W-1:0] lim_max;
  always_comb lim_max = (limit < CNT_W'(2)) ? '0 : limit - CNT_W'(1);

  assert_reset_val_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!tc && count == ($past(dir_down) ? $past(lim_max) : '0)));

  assert_up_incr_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(en) && !$past(dir_down) && !tc) |-> count == $past(count) + CNT_W'(1));

  assert_up_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(en) && !$past(dir_down) && tc) |-> count == '0);

  assert_dn_decr_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(en) && $past(dir_down) && !tc) |-> count == $past(count) - CNT_W'(1));

  assert_dn_reload_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(en) && $past(dir_down) && tc) |-> ($past(count) == '0 && count == $past(lim_max)));

  assert_tc_source_R9: assert property (@(posedge clk) disable iff (rst)
    tc |-> (!$past(rst) && $past(en)));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(en)) |-> ($stable(count) && !tc));

  assert_mod_one_R11: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(en) && $past(limit) < CNT_W'(2) && $past(count) == '0) |-> (count == '0 && tc));
endmodule

bind modn_frame_counter modn_frame_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .en(en), .dir_down(dir_down),
  .limit(limit), .count(count), .tc(tc)
);

// File: tb/modn_frame_counter_tb.sv
module modn_frame_counter_tb;
  localparam int W = 8;
  localparam time HALF = 10ns;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         en = 1'b0;
  logic         dir_down = 1'b0;
  logic [W-1:0] limit = W'(20);
  logic [W-1:0] count;
  logic         tc;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [W-1:0] q_cnt[$];
  logic         q_tc[$];
  string        q_tag[$];
  logic [W-1:0] m_cnt = '0;

  always #HALF clk = ~clk;

  modn_frame_counter #(.CNT_W(W)) u_dut (
    .clk(clk), .rst(rst), .en(en), .dir_down(dir_down),
    .limit(limit), .count(count), .tc(tc)
  );

  // Driver: apply inputs at the falling edge and queue the expected result.
  task automatic step(input logic r, input logic e, input logic d,
                      input logic [W-1:0] l, input string tag);
    logic [W-1:0] top;
    logic         t;
    @(negedge clk);
    rst = r; en = e; dir_down = d; limit = l;
    top = (l <= 1) ? '0 : l - 1;
    t = 1'b0;
    if (r) m_cnt = d ? top : '0;
    else if (e) begin
      if (!d) begin
        if (m_cnt >= top) begin m_cnt = '0; t = 1'b1; end
        else m_cnt = m_cnt + 1;
      end else begin
        if (m_cnt == 0) begin m_cnt = top; t = 1'b1; end
        else m_cnt = m_cnt - 1;
      end
    end
    q_cnt.push_back(m_cnt);
    q_tc.push_back(t);
    q_tag.push_back(tag);
  endtask

  // Monitor: compare shortly after each rising edge.
  always @(posedge clk) begin
    #5ns;
    if (q_cnt.size() > 0) begin
      logic [W-1:0] ec;
      logic         et;
      string        tg;
      ec = q_cnt.pop_front();
      et = q_tc.pop_front();
      tg = q_tag.pop_front();
      total++;
      if (count !== ec || tc !== et) begin
        bad++;
        $display("FAIL %s: got count=%0d tc=%0b, expected count=%0d tc=%0b",
                 tg, count, tc, ec, et);
      end
    end
  end

  initial begin
    // R1: reset, ascending
    step(1, 0, 0, 20, "R1");
    // R2, R3: 25 steps at limit 20 cover the full run and one wrap
    for (int i = 0; i < 25; i++) step(0, 1, 0, 20, (i == 19) ? "R3" : "R2");
    // R10: idle holds the count, no pulse
    for (int i = 0; i < 3; i++) step(0, 0, 0, 20, "R10");
    // R4: run up to 15, then lower the limit beneath the count
    for (int i = 0; i < 10; i++) step(0, 1, 0, 20, "R2");
    step(0, 1, 0, 10, "R4");
    step(0, 1, 0, 10, "R9");
    // R5: count at 4 with limit 10, then limit 5 wraps at once
    for (int i = 0; i < 3; i++) step(0, 1, 0, 10, "R2");
    step(0, 1, 0, 5, "R5");
    step(0, 1, 0, 5, "R9");
    // R1: reset, descending at limit 123
    step(1, 0, 1, 123, "R1");
    for (int i = 0; i < 5; i++) step(0, 1, 1, 123, "R6");
    // R8: limit drops to 7; the descent from 117 continues
    for (int i = 0; i < 117; i++) step(0, 1, 1, 7, "R8");
    step(0, 1, 1, 7, "R7");
    for (int i = 0; i < 8; i++) step(0, 1, 1, 7, (i == 6) ? "R7" : "R6");
    step(0, 0, 1, 7, "R10");
    // R11: modulus 1 in both forms
    step(1, 0, 0, 0, "R1");
    for (int i = 0; i < 3; i++) step(0, 1, 0, 0, "R11");
    for (int i = 0; i < 3; i++) step(0, 1, 0, 1, "R11");
    step(1, 0, 1, 1, "R1");
    for (int i = 0; i < 3; i++) step(0, 1, 1, 1, "R11");
    step(0, 0, 1, 1, "R10");
    @(posedge clk);
    @(posedge clk);
    #8ns;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(2 * HALF * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule